// File: doc/BRIEF.md
# Audio Clock Mode Controller

This block sits between the master clock and the serial and filter logic of an audio converter. It reads two static mode pins and either generates the frame clock and bit clock itself (master operation) or listens to a frame clock that arrives from outside (slave operation). In both cases it publishes the speed mode, the internal master-clock divider select, and a clock enable for the modulator. The modulator enable runs at half the internal master clock.

In master operation the speed mode comes straight from the pins. The frame clock and bit clock are counter bits of a free-running divider. The block always uses the larger ratio of the chosen speed mode, so the divider select is 1.

In slave operation the pins carry no speed information. The block counts master-clock cycles over each incoming frame period. It also counts pulses of a slow reference tick over the same period. These two counts pick the speed mode and the divider. A result is committed only when two frame periods in a row give the same result. Until the first commit, the modulator enable stays off.

The controller state machine has six states:
- INIT is entered at reset and after any change of the pins. It goes to MASTER when the pins are not 11, and to SEEK when they are 11.
- MASTER holds its settings until the pins change.
- SEEK waits for the first complete measurement, then goes to ACQ.
- ACQ goes to LOCK on two matching valid results. It goes to FAULT on two matching error results.
- LOCK goes to FAULT on two matching error results. On two matching valid results it stays in LOCK and takes up the new settings.
- FAULT goes to LOCK on two matching valid results.
- Every state except INIT returns to INIT when the pins change.

Top module: `audio_clk_mode_ctrl`

## Requirements
- R1: Mode pins 00, 01 and 10 select master operation with speed code 0 (single), 1 (double) and 2 (quad); in master operation `master_mode`=1, `mclk_div2`=1 and `locked`=1. Pins 11 select slave operation (`master_mode`=0).
- R2: In master operation, `lrclk_out` has a period of 512, 256 or 128 master-clock cycles for speed codes 0, 1 and 2. Each period contains exactly 64 rising edges of `bclk_out`.
- R3: `mod_clk_en` pulses once every 2 cycles when `mclk_div2`=0 and once every 4 cycles when `mclk_div2`=1. It is 0 whenever `locked`=0.
- R4: In slave operation, a frame period within RATIO_TOL cycles of 512 selects single speed (code 0) with `mclk_div2`=1.
- R5: In slave operation, a period near 256 selects single speed with `mclk_div2`=0 when at least SLOW_TICKS reference ticks fall in one frame period. Otherwise it selects double speed (code 1) with `mclk_div2`=1.
- R6: In slave operation, a period near 128 selects double speed with `mclk_div2`=0 when at least FAST_TICKS reference ticks fall in one frame period. Otherwise it selects quad speed (code 2) with `mclk_div2`=1.
- R7: In slave operation, a period near 64, or a period outside every window, sets `ratio_err`=1 and `locked`=0 once confirmed, and `mod_clk_en` stays 0.
- R8: A slave result is committed only after two consecutive identical measurements. After entering slave operation, `locked` stays 0 until such a pair arrives.
- R9: During and just after reset, `locked`, `ratio_err`, `master_mode`, `lrclk_out`, `bclk_out` and `mod_clk_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_pins | input | 2 | Mode select: 00/01/10 master single/double/quad, 11 slave |
| lrclk_in | input | 1 | Frame clock from outside (slave operation) |
| ref_tick | input | 1 | One-cycle reference pulse, synchronous to clk |
| lrclk_out | output | 1 | Generated frame clock (master operation) |
| bclk_out | output | 1 | Generated bit clock, 64 per frame (master operation) |
| master_mode | output | 1 | 1 while in master operation |
| speed_mode | output | 2 | 0 single, 1 double, 2 quad |
| mclk_div2 | output | 1 | 1 selects internal master clock divided by 2 |
| mod_clk_en | output | 1 | Modulator clock enable |
| locked | output | 1 | Settings valid and enables running |
| ratio_err | output | 1 | Confirmed unsupported slave ratio |

## Verification
The hardest condition to reach from the ports is a slave stream that never produces two matching measurements in a row. Under such a stream the block must stay unlocked indefinitely. The bench reaches it by switching the pins to master and back to slave to clear any earlier lock. It then drives a frame clock whose period alternates between 512 and 128 cycles every frame, and checks that `locked` and `mod_clk_en` stay low. Random slave frames, with jittered periods and two reference-tick rates, cover the 256 and 128 boundary decisions on both sides.

// File: rtl/acmc_pkg.sv
package acmc_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_NONE   = 2'd3
    } speed_e;

    typedef struct packed {
        logic   err;
        speed_e speed;
        logic   div2;
    } rate_cls_t;

    localparam logic [1:0] PINS_SLAVE = 2'b11;

    function automatic logic in_win(input int unsigned val, input int unsigned ctr,
                                    input int unsigned tol);
        return (val + tol >= ctr) && (val <= ctr + tol);
    endfunction

    function automatic rate_cls_t classify(input int unsigned period,
                                           input int unsigned ticks,
                                           input int unsigned tol,
                                           input int unsigned slow_ticks,
                                           input int unsigned fast_ticks);
        rate_cls_t c;
        c = '{err: 1'b1, speed: SPD_NONE, div2: 1'b0};
        if (in_win(period, 512, tol)) begin
            c = '{err: 1'b0, speed: SPD_SINGLE, div2: 1'b1};
        end else if (in_win(period, 256, tol)) begin
            if (ticks >= slow_ticks) c = '{err: 1'b0, speed: SPD_SINGLE, div2: 1'b0};
            else                     c = '{err: 1'b0, speed: SPD_DOUBLE, div2: 1'b1};
        end else if (in_win(period, 128, tol)) begin
            if (ticks >= fast_ticks) c = '{err: 1'b0, speed: SPD_DOUBLE, div2: 1'b0};
            else                     c = '{err: 1'b0, speed: SPD_QUAD,   div2: 1'b1};
        end
        return c;
    endfunction

endpackage

// File: rtl/acmc_master_div.sv
module acmc_master_div #(
    parameter int LR_W = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] speed,
    output logic       lrclk_o,
    output logic       bclk_o
);
    localparam int BCK_TOP = LR_W - 7;

    logic [LR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        unique case (speed)
            2'd0:    begin lrclk_o = cnt_q[LR_W-1]; bclk_o = cnt_q[BCK_TOP];   end
            2'd1:    begin lrclk_o = cnt_q[LR_W-2]; bclk_o = cnt_q[BCK_TOP-1]; end
            default: begin lrclk_o = cnt_q[LR_W-3]; bclk_o = cnt_q[BCK_TOP-2]; end
        endcase
    end

    // R2: every frame edge coincides with a low bit clock
    a_r2_lr_aligned: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(speed) && $rose(lrclk_o)) |-> !bclk_o);

endmodule

// File: rtl/acmc_ratio_meter.sv
module acmc_ratio_meter import acmc_pkg::*; #(
    parameter int PER_W      = 10,
    parameter int TICK_W     = 8,
    parameter int TOL        = 8,
    parameter int SLOW_TICKS = 8,
    parameter int FAST_TICKS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      lrclk_in,
    input  logic      ref_tick,
    output logic      meas_vld,
    output rate_cls_t meas_cls
);
    localparam logic [PER_W-1:0]  PER_MAX  = {PER_W{1'b1}};
    localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};

    logic [2:0]        lr_sync;
    logic              rise;
    logic              armed;
    logic [PER_W-1:0]  per_cnt;
    logic [TICK_W-1:0] tick_cnt;
    int unsigned       per_now;
    int unsigned       tick_now;

    always_ff @(posedge clk) begin
        if (rst || !en) lr_sync <= '0;
        else            lr_sync <= {lr_sync[1:0], lrclk_in};
    end

    assign rise     = lr_sync[1] & ~lr_sync[2];
    assign per_now  = 32'(per_cnt) + 32'd1;
    assign tick_now = 32'(tick_cnt) + 32'(ref_tick);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            armed    <= 1'b0;
            per_cnt  <= '0;
            tick_cnt <= '0;
            meas_vld <= 1'b0;
            meas_cls <= '{err: 1'b1, speed: SPD_NONE, div2: 1'b0};
        end else begin
            meas_vld <= 1'b0;
            if (rise) begin
                armed    <= 1'b1;
                per_cnt  <= '0;
                tick_cnt <= '0;
                if (armed) begin
                    meas_vld <= 1'b1;
                    meas_cls <= classify(per_now, tick_now, TOL, SLOW_TICKS, FAST_TICKS);
                end
            end else begin
                if (per_cnt != PER_MAX) per_cnt <= per_cnt + 1'b1;
                if (ref_tick && tick_cnt != TICK_MAX) tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // R8: measurements are spaced by at least one frame edge detection
    a_r8_meas_spacing: assert property (@(posedge clk) disable iff (rst)
        meas_vld |=> !meas_vld);

endmodule

// File: rtl/acmc_ctrl_fsm.sv
module acmc_ctrl_fsm import acmc_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_pins,
    input  logic       meas_vld,
    input  rate_cls_t  meas_cls,
    output logic       is_master,
    output logic       slave_en,
    output logic [1:0] speed,
    output logic       div2,
    output logic       locked,
    output logic       ratio_err
);
    typedef enum logic [2:0] {
        ST_INIT, ST_MASTER, ST_SEEK, ST_ACQ, ST_LOCK, ST_FAULT
    } st_e;

    st_e        state_q, state_d;
    logic [1:0] pins_q;
    logic       pin_chg;
    rate_cls_t  prev_q;
    logic       match;
    logic       in_slave;

    assign pin_chg  = (mode_pins != pins_q);
    assign match    = meas_vld && (meas_cls == prev_q);
    assign in_slave = (state_q == ST_SEEK) || (state_q == ST_ACQ) ||
                      (state_q == ST_LOCK) || (state_q == ST_FAULT);
    assign is_master = (state_q == ST_MASTER);
    assign slave_en  = in_slave;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INIT;
            pins_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            pins_q  <= mode_pins;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:   state_d = (mode_pins == PINS_SLAVE) ? ST_SEEK : ST_MASTER;
            ST_MASTER: state_d = ST_MASTER;
            ST_SEEK:   if (meas_vld) state_d = ST_ACQ;
            ST_ACQ:    if (match) state_d = meas_cls.err ? ST_FAULT : ST_LOCK;
            ST_LOCK:   if (match && meas_cls.err) state_d = ST_FAULT;
            ST_FAULT:  if (match && !meas_cls.err) state_d = ST_LOCK;
            default:   state_d = ST_INIT;
        endcase
        if (state_q != ST_INIT && pin_chg) state_d = ST_INIT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            speed     <= 2'd0;
            div2      <= 1'b0;
            locked    <= 1'b0;
            ratio_err <= 1'b0;
            prev_q    <= '{err: 1'b1, speed: SPD_NONE, div2: 1'b0};
        end else begin
            unique case (state_q)
                ST_INIT: begin
                    prev_q    <= '{err: 1'b1, speed: SPD_NONE, div2: 1'b0};
                    ratio_err <= 1'b0;
                    if (mode_pins != PINS_SLAVE) begin
                        speed  <= mode_pins;
                        div2   <= 1'b1;
                        locked <= 1'b1;
                    end else begin
                        speed  <= 2'd0;
                        div2   <= 1'b0;
                        locked <= 1'b0;
                    end
                end
                ST_MASTER: ;
                default: begin
                    if (meas_vld) prev_q <= meas_cls;
                    if (match && state_q != ST_SEEK) begin
                        if (meas_cls.err) begin
                            locked    <= 1'b0;
                            ratio_err <= 1'b1;
                        end else begin
                            locked    <= 1'b1;
                            ratio_err <= 1'b0;
                            speed     <= meas_cls.speed;
                            div2      <= meas_cls.div2;
                        end
                    end
                end
            endcase
        end
    end

    // R7: an error result never coexists with a lock
    a_r7_err_not_locked: assert property (@(posedge clk) disable iff (rst)
        ratio_err |-> !locked);

    // R1: master operation always runs the larger ratio
    a_r1_master_settings: assert property (@(posedge clk) disable iff (rst)
        is_master |-> (div2 && locked && speed != 2'd3));

    // R8: slave settings move only on a measurement
    a_r8_commit_on_measure: assert property (@(posedge clk) disable iff (rst)
        (in_slave && !meas_vld) |=> $stable({speed, div2, locked, ratio_err}));

endmodule

// File: rtl/acmc_mod_en.sv
module acmc_mod_en (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic div2,
    output logic mod_en
);
    logic [1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst || !run) ph_q <= 2'd0;
        else             ph_q <= ph_q + 2'd1;
    end

    assign mod_en = run && (div2 ? (ph_q == 2'd3) : ph_q[0]);

    // R3: enables are never back to back
    a_r3_spacing: assert property (@(posedge clk) disable iff (rst)
        mod_en |=> !mod_en);

    // R3: no enable while not running
    a_r3_no_mod_unlocked: assert property (@(posedge clk) disable iff (rst)
        !run |-> !mod_en);

endmodule

// File: rtl/audio_clk_mode_ctrl.sv
module audio_clk_mode_ctrl import acmc_pkg::*; #(
    parameter int RATIO_TOL  = 8,
    parameter int SLOW_TICKS = 8,
    parameter int FAST_TICKS = 4,
    parameter int PER_W      = 10,
    parameter int TICK_W     = 8,
    parameter int LR_W       = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_pins,
    input  logic       lrclk_in,
    input  logic       ref_tick,
    output logic       lrclk_out,
    output logic       bclk_out,
    output logic       master_mode,
    output logic [1:0] speed_mode,
    output logic       mclk_div2,
    output logic       mod_clk_en,
    output logic       locked,
    output logic       ratio_err
);
    logic [1:0] rst_sync;
    logic       rst;
    logic       slave_en;
    logic       meas_vld;
    rate_cls_t  meas_cls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync <= 2'b11;
        else        rst_sync <= {rst_sync[0], 1'b0};
    end
    assign rst = rst_sync[1];

    acmc_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mode_pins (mode_pins),
        .meas_vld  (meas_vld),
        .meas_cls  (meas_cls),
        .is_master (master_mode),
        .slave_en  (slave_en),
        .speed     (speed_mode),
        .div2      (mclk_div2),
        .locked    (locked),
        .ratio_err (ratio_err)
    );

    acmc_ratio_meter #(
        .PER_W      (PER_W),
        .TICK_W     (TICK_W),
        .TOL        (RATIO_TOL),
        .SLOW_TICKS (SLOW_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_meter (
        .clk      (clk),
        .rst      (rst),
        .en       (slave_en),
        .lrclk_in (lrclk_in),
        .ref_tick (ref_tick),
        .meas_vld (meas_vld),
        .meas_cls (meas_cls)
    );

    acmc_master_div #(.LR_W(LR_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (master_mode),
        .speed   (speed_mode),
        .lrclk_o (lrclk_out),
        .bclk_o  (bclk_out)
    );

    acmc_mod_en u_mod (
        .clk    (clk),
        .rst    (rst),
        .run    (locked),
        .div2   (mclk_div2),
        .mod_en (mod_clk_en)
    );

endmodule

// File: tb/audio_clk_mode_ctrl_test.sv
module audio_clk_mode_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_pins = 2'b11;
    logic       lrclk_in = 1'b0;
    logic       ref_tick = 1'b0;
    logic       lrclk_out, bclk_out, master_mode, mclk_div2, mod_clk_en, locked, ratio_err;
    logic [1:0] speed_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int lr_per = 256;
    int lr_cur = 256;
    int lr_c = 0;
    int tk_per = 16;
    int tk_c = 0;
    bit alt = 0;

    always #4 clk = ~clk;

    audio_clk_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .lrclk_in(lrclk_in),
        .ref_tick(ref_tick), .lrclk_out(lrclk_out), .bclk_out(bclk_out),
        .master_mode(master_mode), .speed_mode(speed_mode), .mclk_div2(mclk_div2),
        .mod_clk_en(mod_clk_en), .locked(locked), .ratio_err(ratio_err)
    );

    // frame clock and reference tick stimulus, driven away from the active edge
    always @(negedge clk) begin
        if (lr_c >= lr_cur - 1) begin
            lr_c = 0;
            if (alt) lr_cur = (lr_cur == 512) ? 128 : 512;
            else     lr_cur = lr_per;
        end else begin
            lr_c = lr_c + 1;
        end
        lrclk_in <= (lr_c < lr_cur / 2);
        tk_c = (tk_c >= tk_per - 1) ? 0 : tk_c + 1;
        ref_tick <= (tk_c == 0);
    end

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected slave result: {err, speed, div2}
    function automatic logic [3:0] exp_slave(input int per, input int tkp);
        int ticks;
        ticks = per / tkp;
        if (per >= 504 && per <= 520) return {1'b0, 2'd0, 1'b1};
        if (per >= 248 && per <= 264) return (ticks >= 8) ? {1'b0, 2'd0, 1'b0} : {1'b0, 2'd1, 1'b1};
        if (per >= 120 && per <= 136) return (ticks >= 4) ? {1'b0, 2'd1, 1'b0} : {1'b0, 2'd2, 1'b1};
        return {1'b1, 2'd0, 1'b0};
    endfunction

    task automatic count_mod(output int n);
        n = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (mod_clk_en) n++;
        end
    endtask

    task automatic slave_case(input int per, input int tkp, input string tag);
        logic [3:0] e;
        int n;
        lr_per = per;
        tk_per = tkp;
        repeat (512 + 5 * per + 40) @(negedge clk);
        e = exp_slave(per, tkp);
        chk(int'(ratio_err), int'(e[3]), {tag, " ratio_err"});
        chk(int'(locked), int'(!e[3]), {tag, " locked"});
        chk(int'(master_mode), 0, "R1 slave master_mode");
        if (!e[3]) begin
            chk(int'(speed_mode), int'(e[2:1]), {tag, " speed"});
            chk(int'(mclk_div2), int'(e[0]), {tag, " div2"});
        end
        count_mod(n);
        chk(n, e[3] ? 0 : (e[0] ? 16 : 32), {"R3 mod pulses ", tag});
    endtask

    task automatic master_case(input int m);
        int per, bcnt, n;
        logic pl, pb;
        mode_pins = 2'(m);
        repeat (600) @(negedge clk);
        chk(int'(master_mode), 1, "R1 master_mode");
        chk(int'(speed_mode), m, "R1 master speed");
        chk(int'(mclk_div2), 1, "R1 master div2");
        chk(int'(locked), 1, "R1 master locked");
        pl = lrclk_out;
        while (!( !pl && lrclk_out)) begin pl = lrclk_out; @(negedge clk); end
        per = 0; bcnt = 0; pl = lrclk_out; pb = bclk_out;
        do begin
            @(negedge clk);
            per++;
            if (!pb && bclk_out) bcnt++;
            pb = bclk_out;
            if (!pl && lrclk_out) break;
            pl = lrclk_out;
        end while (per < 2000);
        chk(per, 512 >> m, "R2 lrclk period");
        chk(bcnt, 64, "R2 bclk per frame");
        count_mod(n);
        chk(n, 16, "R3 master mod pulses");
    endtask

    initial begin
        int n;
        int ratios[5] = '{512, 256, 128, 64, 384};
        void'($urandom(32'd5341));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(int'(locked), 0, "R9 locked");
        chk(int'(ratio_err), 0, "R9 ratio_err");
        chk(int'(master_mode), 0, "R9 master_mode");
        chk(int'(lrclk_out), 0, "R9 lrclk_out");
        chk(int'(bclk_out), 0, "R9 bclk_out");
        chk(int'(mod_clk_en), 0, "R9 mod_clk_en");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(int'(locked), 0, "R9 locked after release");

        // directed slave corners
        slave_case(512, 16, "R4");
        slave_case(256, 16, "R5 slow");
        slave_case(256, 64, "R5 fast");
        slave_case(128, 16, "R6 slow");
        slave_case(128, 64, "R6 fast");
        slave_case(64, 16, "R7 ratio64");
        slave_case(384, 16, "R7 off-window");
        slave_case(520, 64, "R4 edge");

        // master modes
        for (int m = 0; m < 3; m++) master_case(m);

        // R8: alternating periods after re-entry never lock
        mode_pins = 2'b11;
        alt = 1;
        for (int k = 0; k < 6; k++) begin
            repeat (320) @(negedge clk);
            chk(int'(locked), 0, "R8 alternating no lock");
            chk(int'(mod_clk_en), 0, "R8 no enable before lock");
        end
        count_mod(n);
        chk(n, 0, "R8 mod pulses while unlocked");
        alt = 0;

        // random slave frames
        for (int k = 0; k < 10; k++) begin
            int r, off, tkp;
            r = ratios[$urandom_range(0, 4)];
            off = int'($urandom_range(0, 8)) - 4;
            tkp = ($urandom_range(0, 1) == 1) ? 64 : 16;
            slave_case(r + off, tkp, "R4-R7 random");
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule